// File: doc/BRIEF.md
# Coarse-Fine Time Interval Digitizer

The block turns the interval between a start event and a stop event into one binary number. A counter clocked by the reference clock counts whole periods and supplies the upper field of the result. A vernier interpolator supplies the lower field. In the interpolator, a faster stop path chases a slower start path through a chain of latch cells. The analog chain is outside the block. Its latch outputs arrive as the vector `fine_i`, which is sampled on the same clock edge as the stop pulse.

The fine vector is decoded into the index of the cell where stop caught start. Vectors with bubbles are resolved at the first 1-to-0 transition. The fine code is appended below the coarse count, and the word is written into a one-entry result store with a valid flag. The flag stays set until the consumer acknowledges it. While a result is pending, no new measurement starts. If the interval runs past the counter range, the store receives a saturated full-scale word and an overflow flag is raised.

The start and stop inputs are one-cycle pulses that are already synchronous to `clk_i`. With `COARSE_W` coarse bits and `FINE_W = log2(N_CELLS)` fine bits, full scale is one fine LSB times 2^(COARSE_W+FINE_W).

Top module: `tdc_interval_digitizer`

## Requirements
- R1: After reset, `valid_o` and `ovf_o` are 0 and `result_o` is 0.
- R2: A start sampled at edge t0 and a stop sampled at edge t0+d (1 <= d <= 2^COARSE_W) make `result_o[RES_W-1:FINE_W]` equal d-1. `valid_o` rises at edge t0+d, with `ovf_o` = 0.
- R3: `result_o[FINE_W-1:0]` is the index of the lowest-numbered 0 bit in the `fine_i` value sampled with the stop. Bits above that 0 are ignored, so bubbles have no effect. If `fine_i` is all ones, the field is N_CELLS-1.
- R4: A stop with no measurement running is ignored, and `valid_o` stays 0.
- R5: A start while a measurement runs restarts it, and the coarse count is taken from the latest start. When start and stop are sampled on the same edge, the start wins and the stop is ignored.
- R6: Suppose a measurement has run 2^COARSE_W edges since its start and none of those edges carried a stop or a start. At that edge, `valid_o` and `ovf_o` rise and `result_o` is all ones.
- R7: `valid_o` and `result_o` hold while `ack_i` is 0. An edge with `valid_o` = 1 and `ack_i` = 1 clears `valid_o` and `ovf_o`, and `result_o` keeps its value. `ack_i` with `valid_o` = 0 has no effect.
- R8: While `valid_o` = 1, start and stop pulses are ignored. `result_o` does not change, and no measurement is running after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start event pulse |
| stop_i | input | 1 | Stop event pulse |
| fine_i | input | N_CELLS | Vernier latch outputs, sampled with the stop |
| ack_i | input | 1 | Consumer acknowledge of the stored result |
| result_o | output | COARSE_W+FINE_W | Stored interval, coarse field above fine field |
| valid_o | output | 1 | Stored result pending |
| ovf_o | output | 1 | Stored result is an overflow |

## Verification
Several internal faults have a distinct signature at the ports:
- A counter that starts at the wrong value or increments on the wrong edge offsets the coarse field in every result. This shows on the first stop.
- A run flag that is not cleared or not restarted shows as a lone stop producing a result, or as a coarse count taken from an earlier start. This is visible on the edge after the stop.
- A decoder scanning from the wrong end shows only with a bubbled or partial vector.
- A wrong overflow compare shows only when a measurement is left open for the full counter range. The overflow is late or early by a fixed number of edges.

The bench compares every output on every cycle against its model. Each of these faults is therefore reported on the first cycle it is visible.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef enum logic {
    MEAS_IDLE = 1'b0,
    MEAS_RUN  = 1'b1
  } meas_state_e;
endpackage

// File: rtl/tdc_therm_dec.sv
module tdc_therm_dec #(
  parameter int N_CELLS = 16,
  localparam int FINE_W = $clog2(N_CELLS)
) (
  input  logic [N_CELLS-1:0] fine_i,
  output logic [FINE_W-1:0]  code_o
);
  // lowest zero = first 1->0 transition; upper bubbles ignored
  always_comb begin
    code_o = FINE_W'(N_CELLS - 1);
    for (int i = N_CELLS - 1; i >= 0; i--) begin
      if (!fine_i[i]) code_o = FINE_W'(i);
    end
  end

  always_comb begin
    if (code_o != '0) AST_FINE_LOW_ONES: assert (fine_i[0]); // R3
  end
endmodule

// File: rtl/tdc_coarse_ctl.sv
module tdc_coarse_ctl
  import tdc_pkg::*;
#(
  parameter int COARSE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                busy_i,
  output logic                cap_o,
  output logic                ovf_o,
  output logic [COARSE_W-1:0] coarse_o
);
  localparam logic [COARSE_W-1:0] CNT_MAX = '1;

  meas_state_e         state_q;
  logic [COARSE_W-1:0] cnt_q;
  logic                run, at_max;

  assign run      = (state_q == MEAS_RUN) && !busy_i && !start_i;
  assign at_max   = (cnt_q == CNT_MAX);
  assign cap_o    = run && stop_i;
  assign ovf_o    = run && !stop_i && at_max;
  assign coarse_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MEAS_IDLE;
      cnt_q   <= '0;
    end else if (!busy_i) begin
      if (start_i) begin
        state_q <= MEAS_RUN;
        cnt_q   <= '0;
      end else if (cap_o || ovf_o) begin
        state_q <= MEAS_IDLE;
      end else if (state_q == MEAS_RUN) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> state_q == MEAS_RUN && cnt_q == '0); // R5
  AST_OVF_ENDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == MEAS_RUN && at_max && !start_i && !stop_i && !busy_i |=> state_q == MEAS_IDLE); // R6
endmodule

// File: rtl/tdc_result_store.sv
module tdc_result_store #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_ovf_i,
  input  logic [RES_W-1:0] wr_data_i,
  input  logic             ack_i,
  output logic [RES_W-1:0] data_o,
  output logic             valid_o,
  output logic             ovf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else if (wr_i) begin
      data_o  <= wr_ovf_i ? '1 : wr_data_i;
      valid_o <= 1'b1;
      ovf_o   <= wr_ovf_i;
    end else if (valid_o && ack_i) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ack_i |=> valid_o && $stable(data_o)); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ack_i |=> !valid_o && !ovf_o); // R7
  AST_NO_WR_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !wr_i); // R8
  AST_OVF_SATURATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> valid_o && data_o == '1); // R6
endmodule

// File: rtl/tdc_interval_digitizer.sv
module tdc_interval_digitizer #(
  parameter int COARSE_W = 8,
  parameter int N_CELLS  = 16,
  localparam int FINE_W  = $clog2(N_CELLS),
  localparam int RES_W   = COARSE_W + FINE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic [N_CELLS-1:0] fine_i,
  input  logic               ack_i,
  output logic [RES_W-1:0]   result_o,
  output logic               valid_o,
  output logic               ovf_o
);
  logic [FINE_W-1:0]   fine_code;
  logic [COARSE_W-1:0] coarse;
  logic                cap, ovf_hit;

  tdc_therm_dec #(.N_CELLS(N_CELLS)) u_dec (
    .fine_i (fine_i),
    .code_o (fine_code)
  );

  tdc_coarse_ctl #(.COARSE_W(COARSE_W)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .busy_i   (valid_o),
    .cap_o    (cap),
    .ovf_o    (ovf_hit),
    .coarse_o (coarse)
  );

  tdc_result_store #(.RES_W(RES_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cap || ovf_hit),
    .wr_ovf_i  (ovf_hit),
    .wr_data_i ({coarse, fine_code}),
    .ack_i     (ack_i),
    .data_o    (result_o),
    .valid_o   (valid_o),
    .ovf_o     (ovf_o)
  );

  AST_STOP_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && stop_i && !cap |=> !valid_o || ovf_o); // R4
  AST_SAME_EDGE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && start_i |=> !valid_o); // R5
endmodule

// File: tb/tb_tdc_interval_digitizer.sv
`timescale 1ns/1ps
module tb_tdc_interval_digitizer;
  localparam int COARSE_W = 8;
  localparam int N_CELLS  = 16;
  localparam int FINE_W   = 4;
  localparam int RES_W    = COARSE_W + FINE_W;
  localparam int CMAX     = (1 << COARSE_W) - 1;
  localparam int FULL     = (1 << RES_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start, stop, ack;
  logic [N_CELLS-1:0] fine;
  logic [RES_W-1:0] result;
  logic valid, ovf;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdc_interval_digitizer #(.COARSE_W(COARSE_W), .N_CELLS(N_CELLS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .fine_i(fine), .ack_i(ack), .result_o(result), .valid_o(valid), .ovf_o(ovf)
  );

  function automatic int fcode(logic [N_CELLS-1:0] v);
    for (int i = 0; i < N_CELLS; i++) if (v[i] == 1'b0) return i;
    return N_CELLS - 1;
  endfunction

  // behavioural reference
  bit m_run = 0, m_valid = 0, m_ovf = 0;
  int m_cnt = 0, m_res = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_valid = 0; m_ovf = 0; m_cnt = 0; m_res = 0;
    end else if (m_valid) begin
      if (ack) begin m_valid = 0; m_ovf = 0; end
    end else if (start) begin
      m_run = 1; m_cnt = 0;
    end else if (m_run && stop) begin
      m_res = m_cnt * N_CELLS + fcode(fine); m_valid = 1; m_run = 0;
    end else if (m_run) begin
      if (m_cnt == CMAX) begin m_res = FULL; m_ovf = 1; m_valid = 1; m_run = 0; end
      else m_cnt++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R7 valid_o vs model", int'(valid), int'(m_valid));
    chk("R6 ovf_o vs model", int'(ovf), int'(m_ovf));
    chk("R2 result_o vs model", int'(result), m_res);
  end

  task automatic cyc(logic st, logic sp, logic [N_CELLS-1:0] fv, logic ak);
    start = st; stop = sp; fine = fv; ack = ak;
    @(posedge clk); @(negedge clk);
  endtask
  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, '0, 0);
  endtask

  initial begin
    start = 0; stop = 0; fine = '0; ack = 0;
    #1;
    chk("R1 valid_o in reset", int'(valid), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid_o after reset", int'(valid), 0);
    chk("R1 ovf_o after reset", int'(ovf), 0);
    chk("R1 result_o after reset", int'(result), 0);

    // R2/R3: basic measurement, coarse 5, fine 6
    cyc(1, 0, '0, 0); idle(5);
    cyc(0, 1, 16'h003F, 0);
    chk("R2 valid_o on stop edge", int'(valid), 1);
    chk("R2 coarse field", int'(result[RES_W-1:FINE_W]), 5);
    chk("R3 fine field clean code", int'(result[FINE_W-1:0]), 6);
    // R8: ignored while pending
    cyc(1, 0, '0, 0); idle(2); cyc(0, 1, 16'h0001, 0);
    chk("R8 result unchanged while pending", int'(result), 5 * N_CELLS + 6);
    idle(3);
    chk("R7 valid held without ack", int'(valid), 1);
    cyc(0, 0, '0, 1);
    chk("R7 ack clears valid", int'(valid), 0);
    chk("R7 result kept after ack", int'(result), 5 * N_CELLS + 6);
    cyc(0, 0, '0, 1);
    chk("R7 ack while idle no effect", int'(valid), 0);
    cyc(0, 1, 16'hFFFF, 0);
    chk("R8 no run left after pending start", int'(valid), 0);

    // R4: lone stop
    cyc(0, 1, 16'h00FF, 0); idle(1);
    chk("R4 lone stop ignored", int'(valid), 0);

    // R3: bubble, coarse 0
    cyc(1, 0, '0, 0); cyc(0, 1, 16'hF5F7, 0);
    chk("R2 coarse zero at d=1", int'(result[RES_W-1:FINE_W]), 0);
    chk("R3 bubble resolved at first zero", int'(result[FINE_W-1:0]), 3);
    cyc(0, 0, '0, 1);
    cyc(1, 0, '0, 0); idle(1); cyc(0, 1, 16'hFFFF, 0);
    chk("R3 all ones saturates", int'(result[FINE_W-1:0]), N_CELLS - 1);
    chk("R2 coarse 1", int'(result[RES_W-1:FINE_W]), 1);
    cyc(0, 0, '0, 1);
    cyc(1, 0, '0, 0); idle(2); cyc(0, 1, 16'hFFFE, 0);
    chk("R3 zero at cell 0", int'(result[FINE_W-1:0]), 0);
    cyc(0, 0, '0, 1);

    // R5: restart, and start+stop same edge
    cyc(1, 0, '0, 0); idle(4); cyc(1, 0, '0, 0); idle(2);
    cyc(1, 1, 16'h0007, 0);
    chk("R5 same-edge start wins", int'(valid), 0);
    idle(1); cyc(0, 1, 16'h0007, 0);
    chk("R5 coarse from latest start", int'(result[RES_W-1:FINE_W]), 1);
    cyc(0, 0, '0, 1);

    // R2 boundary: stop on last in-range edge
    cyc(1, 0, '0, 0); idle(CMAX); cyc(0, 1, 16'h000F, 0);
    chk("R2 max coarse no overflow", int'(ovf), 0);
    chk("R2 max coarse value", int'(result[RES_W-1:FINE_W]), CMAX);
    cyc(0, 0, '0, 1);

    // R6: overflow
    cyc(1, 0, '0, 0); idle(CMAX);
    chk("R6 no overflow before range end", int'(valid), 0);
    idle(1);
    chk("R6 overflow flag", int'(ovf), 1);
    chk("R6 saturated result", int'(result), FULL);
    cyc(0, 1, 16'h0003, 0);
    chk("R8 late stop ignored", int'(result), FULL);
    cyc(0, 0, '0, 1);
    chk("R7 ack clears ovf", int'(ovf), 0);
    idle(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule